// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and a calendar as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month, two-digit year and a century flag. A one-cycle pulse on `tick`, made elsewhere from the oscillator prescaler, advances the time by one second. Every carry, from seconds up to the century flag, settles in the same clock edge that takes the tick.

A host loads any single field through a byte-wide write port selected by a three-bit code. It reads all fields at once as seven byte outputs. The seconds byte carries a halt flag in bit 7, and the hours byte carries a century-enable flag and the century flag itself. Bits that have no meaning in a field are dropped when written and read back as zero.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs read seconds 0x00 with the halt flag clear, minutes 0x00, hours 0x00 with both century flags clear, day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Each of seconds and minutes is packed BCD (tens digit in bits 6:4, units in bits 3:0) and counts 00 to 59. Seconds step on each accepted tick. Minutes step only on the tick where seconds wrap from 59 to 00.
- R3: Hours are packed BCD in bits 5:0 and count 00 to 23 (24-hour only), stepping when minutes wrap. The wrap from 23 to 00 advances both the day of week and the date.
- R4: Day of week sits in bits 2:0, counts 01 to 07 and wraps from 07 to 01.
- R5: Date is packed BCD and counts 01 up to the length of the current month, then wraps to 01 and steps the month. The length is 30 for months 04, 06, 09 and 11, and 31 for months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02 the date wraps after 29 when the year is a multiple of 4 (00 counts as one), and after 28 otherwise.
- R7: Month counts 01 to 12. Its wrap from 12 to 01 steps the year. The year counts 00 to 99 in packed BCD and wraps to 00.
- R8: Hours bit 7 is century enable and bit 6 is the century flag. The flag inverts on the tick where the year wraps from 99 to 00 if the enable is 1. It holds if the enable is 0.
- R9: While seconds bit 7 (halt) is 1, a tick changes no field.
- R10: A write with select codes 0 to 6 loads seconds, minutes, hours, day of week, date, month or year. The new value is visible after the next clock edge and leaves every other field unchanged. A tick in the same cycle as a write is dropped. Select code 7 changes nothing. The next accepted tick counts from the written value.
- R11: On write, minutes bit 7, hours bits 5:0 above the hour value, day-of-week bits 7:3, date bits 7:6 and month bits 7:5 are discarded and read back as 0.
- R12: With no tick and no write, no field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, one second has elapsed |
| wr_en | input | 1 | Load the selected field this cycle |
| wr_sel | input | 3 | Field select: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year |
| wr_data | input | 8 | Byte to load |
| sec_o | output | 8 | Halt flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Century enable, century flag, BCD hours |
| dow_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | BCD day of month |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The main sweep places the clock at 23:59:59 on the second-to-last day of every month of all 100 years and ticks over two midnights. This separates the 30-day, 31-day, leap February and common February cases, and shows the month and year carries. A December of year 99, run with the century enable both set and clear, tells a toggling century flag from a held one. A free run of a hundred ticks across midnight exercises the seconds and minutes BCD carries. Short directed patterns then cover halt, idle cycles, a write colliding with a tick, and junk bits in written bytes.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);

  logic       halt_q;
  logic [6:0] sec_q;
  logic [6:0] min_q;
  logic       cen_en_q, cen_q;
  logic [5:0] hr_q;
  logic [2:0] dow_q;
  logic [5:0] date_q;
  logic [4:0] mon_q;
  logic [7:0] yr_q;

  logic [6:0] sec_nx, min_nx;
  logic [5:0] hr_nx, date_nx, last_day;
  logic [4:0] mon_nx;
  logic [7:0] yr_nx;
  logic       leap, short_mon;
  logic       step, c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  assign sec_nx  = (sec_q[3:0]  >= 4'd9) ? {sec_q[6:4]  + 3'd1, 4'd0} : {sec_q[6:4],  sec_q[3:0]  + 4'd1};
  assign min_nx  = (min_q[3:0]  >= 4'd9) ? {min_q[6:4]  + 3'd1, 4'd0} : {min_q[6:4],  min_q[3:0]  + 4'd1};
  assign hr_nx   = (hr_q[3:0]   >= 4'd9) ? {hr_q[5:4]   + 2'd1, 4'd0} : {hr_q[5:4],   hr_q[3:0]   + 4'd1};
  assign date_nx = (date_q[3:0] >= 4'd9) ? {date_q[5:4] + 2'd1, 4'd0} : {date_q[5:4], date_q[3:0] + 4'd1};
  assign mon_nx  = (mon_q[3:0]  >= 4'd9) ? {mon_q[4]    + 1'b1, 4'd0} : {mon_q[4],    mon_q[3:0]  + 4'd1};
  assign yr_nx   = (yr_q[3:0]   >= 4'd9) ? {yr_q[7:4]   + 4'd1, 4'd0} : {yr_q[7:4],   yr_q[3:0]   + 4'd1};

  assign leap      = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                             : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);
  assign short_mon = (mon_q == 5'h04) || (mon_q == 5'h06) || (mon_q == 5'h09) || (mon_q == 5'h11);
  assign last_day  = (mon_q == 5'h02) ? (leap ? 6'h29 : 6'h28) : (short_mon ? 6'h30 : 6'h31);

  assign step  = tick & ~halt_q & ~wr_en;
  assign c_min = step  & (sec_q  >= 7'h59);
  assign c_hr  = c_min & (min_q  >= 7'h59);
  assign c_day = c_hr  & (hr_q   >= 6'h23);
  assign c_mon = c_day & (date_q >= last_day);
  assign c_yr  = c_mon & (mon_q  >= 5'h12);
  assign c_cen = c_yr  & (yr_q   >= 8'h99) & cen_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q   <= 1'b0;
      sec_q    <= 7'h00;
      min_q    <= 7'h00;
      cen_en_q <= 1'b0;
      cen_q    <= 1'b0;
      hr_q     <= 6'h00;
      dow_q    <= 3'd1;
      date_q   <= 6'h01;
      mon_q    <= 5'h01;
      yr_q     <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: {halt_q, sec_q} <= wr_data;
        3'd1: min_q <= wr_data[6:0];
        3'd2: {cen_en_q, cen_q, hr_q} <= wr_data;
        3'd3: dow_q <= wr_data[2:0];
        3'd4: date_q <= wr_data[5:0];
        3'd5: mon_q <= wr_data[4:0];
        3'd6: yr_q <= wr_data;
        default: ;
      endcase
    end else begin
      if (step)  sec_q  <= c_min ? 7'h00 : sec_nx;
      if (c_min) min_q  <= c_hr ? 7'h00 : min_nx;
      if (c_hr)  hr_q   <= c_day ? 6'h00 : hr_nx;
      if (c_day) begin
        dow_q  <= (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;
        date_q <= c_mon ? 6'h01 : date_nx;
      end
      if (c_mon) mon_q  <= c_yr ? 5'h01 : mon_nx;
      if (c_yr)  yr_q   <= (yr_q >= 8'h99) ? 8'h00 : yr_nx;
      if (c_cen) cen_q  <= ~cen_q;
    end
  end

  assign sec_o  = {halt_q, sec_q};
  assign min_o  = {1'b0, min_q};
  assign hour_o = {cen_en_q, cen_q, hr_q};
  assign dow_o  = {5'd0, dow_q};
  assign date_o = {2'd0, date_q};
  assign mon_o  = {3'd0, mon_q};
  assign year_o = yr_q;

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(dow_o)
                           && $stable(date_o) && $stable(mon_o) && $stable(year_o)));

  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o)
                              && $stable(year_o)));

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sec_o[6:0] != 7'h59) |=> $stable(min_o));

  p_century_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && year_o != 8'h99) |=> $stable(hour_o[7:6]));

  p_dow_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && dow_o >= 8'd1 && dow_o <= 8'd7) |=> (dow_o >= 8'd1 && dow_o <= 8'd7));

  p_date_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && date_o != 8'h00) |=> (date_o != 8'h00));

endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;

  int vectors = 0;
  int misses = 0;

  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
  bit m_halt, m_ce, m_cb;

  always #(PERIOD/2) clk = ~clk;

  bcd_calendar u_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .mon_o(mon_o), .year_o(year_o)
  );

  function automatic logic [7:0] to_bcd(int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int month_len(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    if (m_halt) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
    m_date++;
    if (m_date <= month_len(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr++;
    if (m_yr <= 99) return;
    m_yr = 0;
    if (m_ce) m_cb = ~m_cb;
  endtask

  task automatic model_write(logic [2:0] s, logic [7:0] d);
    case (s)
      3'd0: begin m_halt = d[7]; m_sec = from_bcd(d & 8'h7F); end
      3'd1: m_min = from_bcd(d & 8'h7F);
      3'd2: begin m_ce = d[7]; m_cb = d[6]; m_hr = from_bcd(d & 8'h3F); end
      3'd3: m_dow = int'(d[2:0]);
      3'd4: m_date = from_bcd(d & 8'h3F);
      3'd5: m_mon = from_bcd(d & 8'h1F);
      3'd6: m_yr = from_bcd(d);
      default: ;
    endcase
  endtask

  task automatic cmp(string tag, string field, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, field, act, exp);
    end
  endtask

  task automatic check(string tag);
    vectors++;
    cmp(tag, "sec",  sec_o,  {m_halt, to_bcd(m_sec)[6:0]});
    cmp(tag, "min",  min_o,  to_bcd(m_min));
    cmp(tag, "hour", hour_o, {m_ce, m_cb, to_bcd(m_hr)[5:0]});
    cmp(tag, "dow",  dow_o,  8'(m_dow));
    cmp(tag, "date", date_o, to_bcd(m_date));
    cmp(tag, "mon",  mon_o,  to_bcd(m_mon));
    cmp(tag, "year", year_o, to_bcd(m_yr));
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(s, d);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_step();
  endtask

  task automatic to_midnight_edge();
    wr(3'd0, 8'h59);
    wr(3'd1, 8'h59);
    wr(3'd2, {m_ce, m_cb, 6'h23});
  endtask

  initial begin
    #(PERIOD * 200000);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
    m_halt = 0; m_ce = 0; m_cb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    // R5 R6 R7 R8 sweep over every month of every year, two midnights each
    for (int y = 0; y < 100; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        wr(3'd6, to_bcd(y));
        wr(3'd5, to_bcd(mo));
        wr(3'd4, to_bcd(month_len(mo, y) - 1));
        m_ce = y[0];
        for (int k = 0; k < 2; k++) begin
          to_midnight_edge();
          do_tick();
          check("R3 R5 R6 R7 R8 midnight");
        end
      end
    end

    // R8: century enable clear holds the flag across 99 -> 00
    wr(3'd2, 8'h40);
    wr(3'd6, 8'h99); wr(3'd5, 8'h12); wr(3'd4, 8'h31);
    to_midnight_edge();
    do_tick();
    check("R8 enable clear");

    // R4: day-of-week wraps 7 -> 1
    wr(3'd3, 8'h07);
    to_midnight_edge();
    do_tick();
    check("R4 dow wrap");

    // R2 R3: free run across midnight from 23:58:50
    wr(3'd0, 8'h50); wr(3'd1, 8'h58); wr(3'd2, 8'h23);
    for (int i = 0; i < 100; i++) begin
      do_tick();
      check("R2 R3 free run");
    end

    // R9: halt freezes everything
    wr(3'd0, 8'hD9);
    for (int i = 0; i < 5; i++) begin
      do_tick();
      check("R9 halted");
    end
    wr(3'd0, 8'h59);
    do_tick();
    check("R9 released");

    // R12: idle cycles
    repeat (6) @(negedge clk);
    check("R12 idle");

    // R10: write and tick together, write wins, no advance
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h33; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    model_write(3'd1, 8'h33);
    check("R10 write with tick");
    wr(3'd7, 8'hFF);
    check("R10 select 7");
    do_tick();
    check("R10 count from written");

    // R11: junk bits discarded
    wr(3'd3, 8'hFD);
    wr(3'd4, 8'hE5);
    wr(3'd5, 8'hF1);
    wr(3'd1, 8'hC5);
    check("R11 masks");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule